// File: doc/BRIEF.md
# Dual-Pixel Stream Intensity Inverter

This block sits inline in a video stream. Every 32-bit stream beat holds two packed 16-bit pixels in YUV 4:2:2 8-bit form, each pixel being one luma byte and one chroma byte. A single control word, written over an AXI4-Lite slave, selects the mode. With the word equal to exactly 1, each pixel is replaced by 16384 minus its value, wrapping in 16 bits. With any other value the beat passes through unchanged. Keep, strobe, user, id, dest and last travel with their beat untouched. Frame and line markers are not interpreted.

The output side is a two-entry registered stage, so the input ready is a flop and backpressure never drops or repeats a beat. The mode is taken at the moment a beat is accepted on the input. A beat already waiting at the output keeps the result it was given when it was accepted.

Top module: `pix_invert_axis`

## Requirements
- R1: Input data bits 31:16 and 15:0 each hold one 16-bit pixel, and each pixel is transformed on its own, with no influence from the other.
- R2: When the control word equals 1, each output pixel equals (16384 - input pixel) mod 65536. Examples: 0x0000 gives 0x4000, 0x4000 gives 0x0000, 0xFFFF gives 0x4001.
- R3: When the control word holds any value other than 1 (0, 2, 0x101, ...), the output data equals the input data bit for bit.
- R4: The keep, strobe, user, id, dest and last fields of each output beat equal those of the input beat it came from.
- R5: Every accepted input beat leaves the output exactly once, in order. Output data and sideband stay stable while the output is valid and not ready.
- R6: Input ready is a registered signal. After reset it is 1 and the output valid is 0. A beat accepted while the output stage is empty or draining is valid at the output in the next cycle. Input ready falls only when two beats are held.
- R7: The mode applied to a beat is the value of the control word at the clock edge that accepts the beat. A write that completes at the same edge affects only beats accepted at later edges.
- R8: The control word sits at byte offset 0 and resets to 0. Each write byte strobe updates its own byte lane, and a read returns the current value.
- R9: Writes to any other offset change nothing. Reads of any other offset return 0.
- R10: Write and read responses are OKAY (00). A write is accepted only when address and data are both valid and no response is pending. A response valid stays high until its ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_axil_awaddr | input | AXIL_ADDR_W | Write address |
| s_axil_awvalid | input | 1 | Write address valid |
| s_axil_awready | output | 1 | Write address ready |
| s_axil_wdata | input | AXIL_DATA_W | Write data |
| s_axil_wstrb | input | AXIL_DATA_W/8 | Write byte strobes |
| s_axil_wvalid | input | 1 | Write data valid |
| s_axil_wready | output | 1 | Write data ready |
| s_axil_bresp | output | 2 | Write response |
| s_axil_bvalid | output | 1 | Write response valid |
| s_axil_bready | input | 1 | Write response ready |
| s_axil_araddr | input | AXIL_ADDR_W | Read address |
| s_axil_arvalid | input | 1 | Read address valid |
| s_axil_arready | output | 1 | Read address ready |
| s_axil_rdata | output | AXIL_DATA_W | Read data |
| s_axil_rresp | output | 2 | Read response |
| s_axil_rvalid | output | 1 | Read data valid |
| s_axil_rready | input | 1 | Read data ready |
| s_axis_tdata | input | PIX_W*NPIX | Input pixels |
| s_axis_tkeep | input | PIX_W*NPIX/8 | Input keep |
| s_axis_tstrb | input | PIX_W*NPIX/8 | Input strobe |
| s_axis_tuser | input | USER_W | Input user |
| s_axis_tid | input | ID_W | Input id |
| s_axis_tdest | input | DEST_W | Input dest |
| s_axis_tlast | input | 1 | Input last |
| s_axis_tvalid | input | 1 | Input valid |
| s_axis_tready | output | 1 | Input ready |
| m_axis_tdata | output | PIX_W*NPIX | Output pixels |
| m_axis_tkeep | output | PIX_W*NPIX/8 | Output keep |
| m_axis_tstrb | output | PIX_W*NPIX/8 | Output strobe |
| m_axis_tuser | output | USER_W | Output user |
| m_axis_tid | output | ID_W | Output id |
| m_axis_tdest | output | DEST_W | Output dest |
| m_axis_tlast | output | 1 | Output last |
| m_axis_tvalid | output | 1 | Output valid |
| m_axis_tready | input | 1 | Output ready |

## Verification
A beat accepted at edge k shows at the output right after edge k if the output stage is free. Otherwise it shows right after the edge that drains the beat ahead of it. Input ready reflects the count of held beats after each edge. A control write takes effect for beats accepted from the next edge on, and read data is valid one edge after the read address handshake. The bench settles its inputs just after each falling edge and samples everything shortly before the next rising edge. At that point it compares the output against the head of a queue whose entries were built with the control value of their own acceptance edge, so every result is checked in the cycle it becomes due.

// File: rtl/pix_inv_pkg.sv
// Package: shared constants for the dual-pixel inverter.
// Assumes a single control word decoded at word index CTRL_WORD.
package pix_inv_pkg;
    localparam logic [1:0]  AXI_RESP_OKAY = 2'b00;
    localparam int unsigned CTRL_WORD     = 0;
    localparam int unsigned BYTE_W        = 8;
endpackage

// File: rtl/pix_inv_lane.sv
// Module: pix_inv_lane
// Transforms one packed pixel. When en is high the result is K - pix,
// kept to PIX_W bits (wraps, no saturation); otherwise pix passes as is.
// Assumes: purely combinational, one instance per pixel in a beat.
module pix_inv_lane #(
    parameter int unsigned PIX_W   = 16,
    parameter int unsigned INV_VAL = 16384
) (
    input  logic             en,
    input  logic [PIX_W-1:0] pix_i,
    output logic [PIX_W-1:0] pix_o
);
    localparam logic [PIX_W-1:0] K = PIX_W'(INV_VAL);

    // Select inverted or original pixel.
    always_comb pix_o = en ? (K - pix_i) : pix_i;
endmodule

// File: rtl/pix_inv_skid.sv
// Module: pix_inv_skid
// Two-entry registered stage between the datapath and the output stream.
// in_ready is a flop: it drops only when both the output and skid
// registers hold beats. Assumes in_data is already processed.
module pix_inv_skid #(
    parameter int unsigned W = 44
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    logic         o_valid_q, sk_valid_q;
    logic [W-1:0] o_data_q, sk_data_q;
    logic         out_free, in_fire;

    // Output stage can take a beat this edge.
    always_comb out_free = !o_valid_q || out_ready;
    // Input handshake.
    always_comb in_fire  = in_valid && !sk_valid_q;

    // Move beats: skid first, then fresh input; park input when blocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid_q  <= 1'b0;
            sk_valid_q <= 1'b0;
            o_data_q   <= '0;
            sk_data_q  <= '0;
        end else if (out_free) begin
            if (sk_valid_q) begin
                o_data_q   <= sk_data_q;
                o_valid_q  <= 1'b1;
                sk_valid_q <= 1'b0;
            end else if (in_fire) begin
                o_data_q  <= in_data;
                o_valid_q <= 1'b1;
            end else begin
                o_valid_q <= 1'b0;
            end
        end else if (in_fire) begin
            sk_data_q  <= in_data;
            sk_valid_q <= 1'b1;
        end
    end

    assign in_ready  = !sk_valid_q;
    assign out_valid = o_valid_q;
    assign out_data  = o_data_q;

    // Stalled output must hold its beat.
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // Skid fills only when the output was blocked.
    assert_skid_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sk_valid_q) |-> $past(o_valid_q && !out_ready));

    // A held skid beat always has an occupied output in front of it.
    assert_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sk_valid_q |-> out_valid);
endmodule

// File: rtl/pix_inv_regs.sv
// Module: pix_inv_regs
// AXI4-Lite slave holding one control word at word CTRL_WORD.
// Write accepted when address and data are both valid and no response
// is pending. Other offsets: writes dropped, reads return 0. All OKAY.
module pix_inv_regs #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned REG_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   awaddr,
    input  logic                awvalid,
    output logic                awready,
    input  logic [REG_W-1:0]    wdata,
    input  logic [REG_W/8-1:0]  wstrb,
    input  logic                wvalid,
    output logic                wready,
    output logic [1:0]          bresp,
    output logic                bvalid,
    input  logic                bready,
    input  logic [ADDR_W-1:0]   araddr,
    input  logic                arvalid,
    output logic                arready,
    output logic [REG_W-1:0]    rdata,
    output logic [1:0]          rresp,
    output logic                rvalid,
    input  logic                rready,
    output logic [REG_W-1:0]    ctrl_o
);
    import pix_inv_pkg::*;
    localparam int unsigned STRB_W   = REG_W / BYTE_W;
    localparam int unsigned WORD_LSB = $clog2(STRB_W);

    logic [REG_W-1:0] ctrl_q, ctrl_d, rdata_q;
    logic             bvalid_q, rvalid_q;
    logic             wr_fire, rd_fire, aw_hit, ar_hit;

    // Handshakes and address decode.
    always_comb begin
        wr_fire = awvalid && wvalid && !bvalid_q;
        rd_fire = arvalid && !rvalid_q;
        aw_hit  = (awaddr >> WORD_LSB) == ADDR_W'(CTRL_WORD);
        ar_hit  = (araddr >> WORD_LSB) == ADDR_W'(CTRL_WORD);
    end

    // Next control word, merged byte by byte under the strobes.
    always_comb begin
        ctrl_d = ctrl_q;
        for (int b = 0; b < STRB_W; b++) begin
            if (wr_fire && aw_hit && wstrb[b])
                ctrl_d[b*BYTE_W +: BYTE_W] = wdata[b*BYTE_W +: BYTE_W];
        end
    end

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    // Write response channel.
    always_ff @(posedge clk) begin
        if (!rst_n)       bvalid_q <= 1'b0;
        else if (wr_fire) bvalid_q <= 1'b1;
        else if (bready)  bvalid_q <= 1'b0;
    end

    // Read data channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else if (rd_fire) begin
            rvalid_q <= 1'b1;
            rdata_q  <= ar_hit ? ctrl_q : '0;
        end else if (rready) begin
            rvalid_q <= 1'b0;
        end
    end

    assign awready = wr_fire;
    assign wready  = wr_fire;
    assign bvalid  = bvalid_q;
    assign bresp   = AXI_RESP_OKAY;
    assign arready = !rvalid_q;
    assign rvalid  = rvalid_q;
    assign rdata   = rdata_q;
    assign rresp   = AXI_RESP_OKAY;
    assign ctrl_o  = ctrl_q;

    // Response valids hold until taken.
    assert_bvalid_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid);
    assert_rvalid_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)));
    // No write handshake means no change to the control word.
    assert_ctrl_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(awvalid && awready) |=> $stable(ctrl_o));
    // A write to another offset leaves the control word alone.
    assert_miss_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid && awready && (awaddr >> WORD_LSB) != ADDR_W'(CTRL_WORD)) |=> $stable(ctrl_o));
endmodule

// File: rtl/pix_invert_axis.sv
// Module: pix_invert_axis (top)
// Stream filter: NPIX packed pixels per beat, each optionally replaced by
// INV_VAL - pixel when the control word equals 1. Sideband copied.
// The mode is applied at input acceptance; results are registered in a
// two-entry output stage. Assumes synchronous active-low reset.
module pix_invert_axis #(
    parameter int unsigned PIX_W       = 16,
    parameter int unsigned NPIX        = 2,
    parameter int unsigned USER_W      = 1,
    parameter int unsigned ID_W        = 1,
    parameter int unsigned DEST_W      = 1,
    parameter int unsigned AXIL_ADDR_W = 4,
    parameter int unsigned AXIL_DATA_W = 32,
    parameter int unsigned INV_VAL     = 16384
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [AXIL_ADDR_W-1:0]     s_axil_awaddr,
    input  logic                       s_axil_awvalid,
    output logic                       s_axil_awready,
    input  logic [AXIL_DATA_W-1:0]     s_axil_wdata,
    input  logic [AXIL_DATA_W/8-1:0]   s_axil_wstrb,
    input  logic                       s_axil_wvalid,
    output logic                       s_axil_wready,
    output logic [1:0]                 s_axil_bresp,
    output logic                       s_axil_bvalid,
    input  logic                       s_axil_bready,
    input  logic [AXIL_ADDR_W-1:0]     s_axil_araddr,
    input  logic                       s_axil_arvalid,
    output logic                       s_axil_arready,
    output logic [AXIL_DATA_W-1:0]     s_axil_rdata,
    output logic [1:0]                 s_axil_rresp,
    output logic                       s_axil_rvalid,
    input  logic                       s_axil_rready,
    input  logic [PIX_W*NPIX-1:0]      s_axis_tdata,
    input  logic [PIX_W*NPIX/8-1:0]    s_axis_tkeep,
    input  logic [PIX_W*NPIX/8-1:0]    s_axis_tstrb,
    input  logic [USER_W-1:0]          s_axis_tuser,
    input  logic [ID_W-1:0]            s_axis_tid,
    input  logic [DEST_W-1:0]          s_axis_tdest,
    input  logic                       s_axis_tlast,
    input  logic                       s_axis_tvalid,
    output logic                       s_axis_tready,
    output logic [PIX_W*NPIX-1:0]      m_axis_tdata,
    output logic [PIX_W*NPIX/8-1:0]    m_axis_tkeep,
    output logic [PIX_W*NPIX/8-1:0]    m_axis_tstrb,
    output logic [USER_W-1:0]          m_axis_tuser,
    output logic [ID_W-1:0]            m_axis_tid,
    output logic [DEST_W-1:0]          m_axis_tdest,
    output logic                       m_axis_tlast,
    output logic                       m_axis_tvalid,
    input  logic                       m_axis_tready
);
    localparam int unsigned DATA_W = PIX_W * NPIX;
    localparam int unsigned KEEP_W = DATA_W / 8;
    localparam int unsigned SIDE_W = 2*KEEP_W + USER_W + ID_W + DEST_W + 1;
    localparam int unsigned PAY_W  = DATA_W + SIDE_W;

    logic [AXIL_DATA_W-1:0] ctrl;
    logic                   inv_en;
    logic [DATA_W-1:0]      proc_data;
    logic [PAY_W-1:0]       pay_in, pay_out;
    logic [SIDE_W-1:0]      side_in;

    pix_inv_regs #(.ADDR_W(AXIL_ADDR_W), .REG_W(AXIL_DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .awaddr  (s_axil_awaddr),
        .awvalid (s_axil_awvalid),
        .awready (s_axil_awready),
        .wdata   (s_axil_wdata),
        .wstrb   (s_axil_wstrb),
        .wvalid  (s_axil_wvalid),
        .wready  (s_axil_wready),
        .bresp   (s_axil_bresp),
        .bvalid  (s_axil_bvalid),
        .bready  (s_axil_bready),
        .araddr  (s_axil_araddr),
        .arvalid (s_axil_arvalid),
        .arready (s_axil_arready),
        .rdata   (s_axil_rdata),
        .rresp   (s_axil_rresp),
        .rvalid  (s_axil_rvalid),
        .rready  (s_axil_rready),
        .ctrl_o  (ctrl)
    );

    // Invert only on an exact match with 1.
    always_comb inv_en = (ctrl == AXIL_DATA_W'(1));

    // One lane per packed pixel.
    for (genvar p = 0; p < NPIX; p++) begin : g_lane
        pix_inv_lane #(.PIX_W(PIX_W), .INV_VAL(INV_VAL)) u_lane (
            .en    (inv_en),
            .pix_i (s_axis_tdata[p*PIX_W +: PIX_W]),
            .pix_o (proc_data[p*PIX_W +: PIX_W])
        );
    end

    // Pack processed data with untouched sideband.
    always_comb begin
        side_in = {s_axis_tkeep, s_axis_tstrb, s_axis_tuser,
                   s_axis_tid, s_axis_tdest, s_axis_tlast};
        pay_in  = {proc_data, side_in};
    end

    pix_inv_skid #(.W(PAY_W)) u_skid (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (s_axis_tvalid),
        .in_ready  (s_axis_tready),
        .in_data   (pay_in),
        .out_valid (m_axis_tvalid),
        .out_ready (m_axis_tready),
        .out_data  (pay_out)
    );

    assign {m_axis_tdata, m_axis_tkeep, m_axis_tstrb, m_axis_tuser,
            m_axis_tid, m_axis_tdest, m_axis_tlast} = pay_out;

    // Beat reaches an idle or draining output one cycle after acceptance.
    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_axis_tvalid && s_axis_tready && (!m_axis_tvalid || m_axis_tready))
        |=> m_axis_tvalid);

    // Sideband forwarded with the beat.
    assert_side_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_axis_tvalid && s_axis_tready && (!m_axis_tvalid || m_axis_tready))
        |=> (m_axis_tlast == $past(s_axis_tlast) && m_axis_tuser == $past(s_axis_tuser)
             && m_axis_tid == $past(s_axis_tid) && m_axis_tdest == $past(s_axis_tdest)
             && m_axis_tkeep == $past(s_axis_tkeep) && m_axis_tstrb == $past(s_axis_tstrb)));

    // Inverted low pixel plus original sums to the constant.
    assert_inv_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_axis_tvalid && s_axis_tready && (!m_axis_tvalid || m_axis_tready) && inv_en)
        |=> (PIX_W'(m_axis_tdata[PIX_W-1:0] + $past(s_axis_tdata[PIX_W-1:0]))
             == PIX_W'(INV_VAL)));

    // Pass-through mode copies data exactly.
    assert_pass_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_axis_tvalid && s_axis_tready && (!m_axis_tvalid || m_axis_tready) && !inv_en)
        |=> (m_axis_tdata == $past(s_axis_tdata)));
endmodule

// File: tb/sim_pix_invert_axis.sv
// Bench: queue-based reference model checked before every rising edge.
module sim_pix_invert_axis;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [3:0]  awaddr = '0, araddr = '0;
    logic        awvalid = 0, wvalid = 0, arvalid = 0;
    logic        bready = 1'b1, rready = 1'b1;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;

    logic [31:0] s_tdata = '0;
    logic [3:0]  s_tkeep = '0, s_tstrb = '0;
    logic        s_tuser = 0, s_tid = 0, s_tdest = 0, s_tlast = 0, s_tvalid = 0;
    logic        s_tready;
    logic [31:0] m_tdata;
    logic [3:0]  m_tkeep, m_tstrb;
    logic        m_tuser, m_tid, m_tdest, m_tlast, m_tvalid;
    logic        m_tready = 1'b0;

    pix_invert_axis u0 (
        .clk(clk), .rst_n(rst_n),
        .s_axil_awaddr(awaddr), .s_axil_awvalid(awvalid), .s_axil_awready(awready),
        .s_axil_wdata(wdata), .s_axil_wstrb(wstrb), .s_axil_wvalid(wvalid),
        .s_axil_wready(wready), .s_axil_bresp(bresp), .s_axil_bvalid(bvalid),
        .s_axil_bready(bready), .s_axil_araddr(araddr), .s_axil_arvalid(arvalid),
        .s_axil_arready(arready), .s_axil_rdata(rdata), .s_axil_rresp(rresp),
        .s_axil_rvalid(rvalid), .s_axil_rready(rready),
        .s_axis_tdata(s_tdata), .s_axis_tkeep(s_tkeep), .s_axis_tstrb(s_tstrb),
        .s_axis_tuser(s_tuser), .s_axis_tid(s_tid), .s_axis_tdest(s_tdest),
        .s_axis_tlast(s_tlast), .s_axis_tvalid(s_tvalid), .s_axis_tready(s_tready),
        .m_axis_tdata(m_tdata), .m_axis_tkeep(m_tkeep), .m_axis_tstrb(m_tstrb),
        .m_axis_tuser(m_tuser), .m_axis_tid(m_tid), .m_axis_tdest(m_tdest),
        .m_axis_tlast(m_tlast), .m_axis_tvalid(m_tvalid), .m_axis_tready(m_tready)
    );

    typedef struct packed {
        logic [31:0] d;
        logic [3:0]  k;
        logic [3:0]  s;
        logic        u, i, de, l, inv;
    } beat_t;

    beat_t       exp_q[$];
    logic [31:0] model_ctrl = '0;
    int          checks = 0, failures = 0;
    int          n_in = 0, n_out = 0;
    int          bp_mode = 0;
    bit          mon_en = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference transform per requirement R2/R3, lanes independent (R1).
    function automatic logic [31:0] ref_data(input logic [31:0] d, input logic [31:0] c);
        logic [15:0] hi, lo;
        if (c != 32'd1) return d;
        hi = 16'd16384 - d[31:16];
        lo = 16'd16384 - d[15:0];
        return {hi, lo};
    endfunction

    // Output backpressure pattern.
    always begin
        @(negedge clk); #1;
        case (bp_mode)
            0: m_tready = 1'b1;
            1: m_tready = ($urandom_range(0, 2) != 0);
            default: m_tready = 1'b0;
        endcase
    end

    // Cycle model: sampled 2 ns before each rising edge.
    always begin
        @(negedge clk); #3;
        if (mon_en) begin
            // R6: input ready low exactly when two beats are held.
            chk(s_tready == (exp_q.size() < 2), "R6", "s_tready", 32'(s_tready),
                32'(exp_q.size() < 2));
            // R5: output valid exactly when a beat is owed.
            chk(m_tvalid == (exp_q.size() != 0), "R5", "m_tvalid", 32'(m_tvalid),
                32'(exp_q.size() != 0));
            if (m_tvalid && exp_q.size() != 0) begin
                // R1 lanes, R2 or R3 by mode; R7: mode taken at acceptance.
                chk(m_tdata == exp_q[0].d, exp_q[0].inv ? "R2" : "R3", "m_tdata",
                    m_tdata, exp_q[0].d);
                chk({m_tkeep, m_tstrb, m_tuser, m_tid, m_tdest, m_tlast} ==
                    {exp_q[0].k, exp_q[0].s, exp_q[0].u, exp_q[0].i, exp_q[0].de, exp_q[0].l},
                    "R4", "sideband",
                    32'({m_tkeep, m_tstrb, m_tuser, m_tid, m_tdest, m_tlast}),
                    32'({exp_q[0].k, exp_q[0].s, exp_q[0].u, exp_q[0].i, exp_q[0].de, exp_q[0].l}));
            end
            if (m_tvalid && m_tready && exp_q.size() != 0) begin
                void'(exp_q.pop_front());
                n_out++;
            end
            if (s_tvalid && s_tready) begin
                beat_t b;
                b.d = ref_data(s_tdata, model_ctrl);
                b.k = s_tkeep; b.s = s_tstrb; b.u = s_tuser; b.i = s_tid;
                b.de = s_tdest; b.l = s_tlast; b.inv = (model_ctrl == 32'd1);
                exp_q.push_back(b);
                n_in++;
            end
            // R7/R8: write lands after this edge; R9: other offsets ignored.
            if (awvalid && awready && (awaddr >> 2) == 4'd0) begin
                for (int b = 0; b < 4; b++)
                    if (wstrb[b]) model_ctrl[b*8 +: 8] = wdata[b*8 +: 8];
            end
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic send(input logic [31:0] d, input logic [3:0] k, input logic [3:0] s,
                        input logic u, input logic i, input logic de, input logic l);
        s_tdata = d; s_tkeep = k; s_tstrb = s; s_tuser = u; s_tid = i;
        s_tdest = de; s_tlast = l; s_tvalid = 1'b1;
        forever begin
            #2;
            if (s_tready) break;
            tick();
        end
        tick();
        s_tvalid = 1'b0;
    endtask

    task automatic send_rand(input int n, input bit gaps);
        for (int j = 0; j < n; j++) begin
            send($urandom, 4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), (j % 8) == 7);
            if (gaps && $urandom_range(0, 3) == 0) tick();
        end
    endtask

    task automatic axil_write(input logic [3:0] a, input logic [31:0] d, input logic [3:0] st);
        awaddr = a; wdata = d; wstrb = st; awvalid = 1'b1; wvalid = 1'b1;
        forever begin
            #2;
            if (awready) break;
            tick();
        end
        tick();
        awvalid = 1'b0; wvalid = 1'b0;
        forever begin
            #2;
            if (bvalid) break;
            tick();
        end
        chk(bresp == 2'b00, "R10", "bresp", 32'(bresp), 32'd0);
        tick();
    endtask

    task automatic axil_read(input logic [3:0] a, output logic [31:0] d);
        araddr = a; arvalid = 1'b1;
        forever begin
            #2;
            if (arready) break;
            tick();
        end
        tick();
        arvalid = 1'b0;
        forever begin
            #2;
            if (rvalid) break;
            tick();
        end
        d = rdata;
        chk(rresp == 2'b00, "R10", "rresp", 32'(rresp), 32'd0);
        tick();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (5) @(negedge clk);
        #1 rst_n = 1'b1;
        #2;
        // R6: reset state.
        chk(s_tready == 1'b1, "R6", "reset s_tready", 32'(s_tready), 32'd1);
        chk(m_tvalid == 1'b0, "R6", "reset m_tvalid", 32'(m_tvalid), 32'd0);
        tick();
        mon_en = 1;
        axil_read(4'h0, rd);
        chk(rd == 32'd0, "R8", "reset ctrl", rd, 32'd0);

        // Pass-through (R3) with sideband variety (R4).
        bp_mode = 0;
        send(32'h1234_ABCD, 4'hF, 4'hA, 1, 0, 1, 0);
        send(32'hFFFF_0000, 4'h3, 4'h5, 0, 1, 0, 1);
        send_rand(12, 1);

        // Invert mode (R2) with wrap corners, lanes differing (R1).
        axil_write(4'h0, 32'd1, 4'hF);
        axil_read(4'h0, rd);
        chk(rd == 32'd1, "R8", "readback 1", rd, 32'd1);
        bp_mode = 1;
        send(32'h0000_4000, 4'hF, 4'hF, 1, 1, 1, 0);
        send(32'hFFFF_4001, 4'hC, 4'h3, 0, 0, 1, 1);
        send(32'h1234_3FFF, 4'h1, 4'h8, 1, 0, 0, 0);
        send(32'h0000_FFFF, 4'hF, 4'h0, 0, 1, 0, 1);
        send_rand(20, 1);

        // Other values pass through (R3).
        axil_write(4'h0, 32'd2, 4'hF);
        send_rand(6, 0);
        axil_write(4'h0, 32'h101, 4'hF);
        send_rand(6, 1);

        // Full stall: input ready must drop after two beats (R6, R5).
        axil_write(4'h0, 32'd1, 4'hF);
        bp_mode = 2;
        fork
            send_rand(5, 0);
            begin repeat (12) @(negedge clk); bp_mode = 1; end
        join

        // Mode changes racing the stream (R7).
        fork
            send_rand(40, 1);
            begin
                repeat (7) tick();
                axil_write(4'h0, 32'd0, 4'hF);
                repeat (5) tick();
                axil_write(4'h0, 32'd1, 4'hF);
                repeat (3) tick();
                axil_write(4'h0, 32'd0, 4'hF);
                axil_write(4'h0, 32'd1, 4'hF);
            end
        join

        // Byte strobes (R8) and other offsets (R9).
        axil_write(4'h0, 32'hAABB_CCDD, 4'hF);
        axil_write(4'h0, 32'h1122_3344, 4'h4);
        axil_read(4'h0, rd);
        chk(rd == 32'hAA22_CCDD, "R8", "strobe merge", rd, 32'hAA22_CCDD);
        axil_write(4'h4, 32'd1, 4'hF);
        axil_read(4'h0, rd);
        chk(rd == 32'hAA22_CCDD, "R9", "miss write ignored", rd, 32'hAA22_CCDD);
        axil_read(4'h4, rd);
        chk(rd == 32'd0, "R9", "miss read zero", rd, 32'd0);
        send_rand(6, 1);

        // Drain and account (R5).
        bp_mode = 0;
        repeat (10) tick();
        chk(exp_q.size() == 0, "R5", "queue drained", 32'(exp_q.size()), 32'd0);
        chk(n_in == n_out, "R5", "beats in vs out", 32'(n_out), 32'(n_in));
        finish_run();
    end
endmodule